// File: doc/BRIEF.md
# System Options Control Block

This block holds the chip-level options a microcontroller sets once during start-up, and the few run-time controls that go with them. Two byte-wide registers sit on a simple synchronous bus. Register reads are combinational, and writes take effect at the clock edge. The first register, the lock register, holds two bits that can be written only once after reset. One bit permits low-power stop entry. The other requests fast wakeup. The second register, the configuration register, can be read and written at any time. It carries a serial-transmit modulation select, a self-clearing timer synchronization trigger and six general option bits.

The block also checks every STOP strobe from the CPU. If stop entry is permitted, it pulses a grant. If not, it pulses an illegal-opcode reset request. When both stop and fast wakeup are enabled, an interrupt that arrives within a short window after the STOP strobe can hang the core. The block reports each such interrupt on a hazard output. The serial transmit data reaches its pin either directly or ANDed with a timer PWM channel.

Top module: `sysopt_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, the lock register is unlocked, and `fast_wake_o` is 0. `stop_grant_o`, `illegal_rst_o`, `wake_hazard_o` and `sync_pulse_o` are also 0, and `tx_pin_o` follows `tx_data_i`.
- R2: The lock register is at offset 4. The first write to it after reset stores bit 0 (stop enable) and bit 1 (fast wakeup). Any later write has no effect until the next reset. Bits 7:2 always read 0.
- R3: If `stop_req_i` is high while stop enable is 0, `illegal_rst_o` is high for exactly the following cycle and `stop_grant_o` stays 0.
- R4: If `stop_req_i` is high while stop enable is 1, `stop_grant_o` is high for exactly the following cycle and `illegal_rst_o` stays 0. The two outputs are never high together, and neither is high in a cycle after one without a strobe.
- R5: `fast_wake_o` equals the stored fast-wakeup bit.
- R6: A STOP strobe taken with both stop enable and fast wakeup set opens a window. The window covers the strobe cycle and the 8 cycles after it. An `irq_i` sampled inside the window raises `wake_hazard_o` in the next cycle. An `irq_i` outside the window, or with fast wakeup clear, does not.
- R7: The configuration register is at offset 5. It is writable at any time. Bits 7 and 5:0 read back as written, and bit 6 always reads 0.
- R8: A write to offset 5 with bit 6 set pulses `sync_pulse_o` high for exactly the following cycle. A write with bit 6 clear causes no pulse.
- R9: With configuration bit 7 at 0, `tx_pin_o` equals `tx_data_i`. With it at 1, `tx_pin_o` equals `tx_data_i` AND `pwm_ch_i`.
- R10: Offsets other than 4 and 5 read 0 and ignore writes. A write to such an offset does not lock the lock register. With `bus_sel` low, `bus_rdata` is 0.
- R11: `cfg_misc_o` equals configuration bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register offset within the block |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| stop_req_i | input | 1 | CPU STOP strobe, one cycle per instruction |
| irq_i | input | 1 | Interrupt request seen by the core |
| stop_grant_o | output | 1 | Stop entry granted, one-cycle pulse |
| illegal_rst_o | output | 1 | Illegal-opcode reset request, one-cycle pulse |
| fast_wake_o | output | 1 | Resume without interrupt service |
| wake_hazard_o | output | 1 | Interrupt seen inside the post-STOP window |
| tx_data_i | input | 1 | Serial transmit data |
| pwm_ch_i | input | 1 | Timer PWM channel output |
| tx_pin_o | output | 1 | Transmit data to the pin |
| sync_pulse_o | output | 1 | Timer PWM synchronization trigger |
| cfg_misc_o | output | 6 | General configuration bits |

## Verification
The assertions assume that `stop_req_i`, `irq_i`, `tx_data_i` and `pwm_ch_i` are already synchronous to the bus clock. They also assume that bus signals change only between clock edges. No assumption is made about STOP strobe spacing, so back-to-back strobes must each produce their own pulse. The bench drives every input on the falling edge and samples on the falling edge. Each STOP strobe lasts one cycle. Interrupt pulses are placed at fixed cycle offsets from the strobe, so that each case lands inside or outside the window by a known count.

// File: rtl/sysopt_pkg.sv
// Package: shared offsets, bit positions and types for the system options block.
// Assumes byte-wide registers; offsets are fixed by the register layout.
package sysopt_pkg;
    localparam int DATA_W      = 8;
    localparam int OFS_LOCK    = 4;
    localparam int OFS_CFG     = 5;
    localparam int LK_STOP_BIT = 0;
    localparam int LK_FAST_BIT = 1;
    localparam int CF_TXMOD    = 7;
    localparam int CF_SYNC     = 6;
    localparam int MISC_W      = 6;

    typedef struct packed {
        logic fast_wake;
        logic stop_en;
    } lock_opts_t;
endpackage

// File: rtl/sysopt_lock_reg.sv
// Module: write-once lock register. The first decoded write after reset
// stores both option bits and sets the lock; later writes are dropped.
// Assumes wr_en is already qualified by select, write and address decode.
module sysopt_lock_reg
    import sysopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wdata,
    output lock_opts_t        opts,
    output logic              locked,
    output logic [DATA_W-1:0] rdata
);
    // Capture the options on the first write, then hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opts   <= '0;
            locked <= 1'b0;
        end else if (wr_en && !locked) begin
            opts.stop_en   <= wdata[LK_STOP_BIT];
            opts.fast_wake <= wdata[LK_FAST_BIT];
            locked         <= 1'b1;
        end
    end

    // Present the stored bits at their positions; other bits read zero.
    always_comb begin
        rdata              = '0;
        rdata[LK_STOP_BIT] = opts.stop_en;
        rdata[LK_FAST_BIT] = opts.fast_wake;
    end
endmodule

// File: rtl/sysopt_cfg_reg.sv
// Module: free read/write configuration register with a self-clearing
// synchronization trigger bit that is never stored.
// Assumes wr_en is already qualified by select, write and address decode.
module sysopt_cfg_reg
    import sysopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              tx_mod,
    output logic [MISC_W-1:0] misc,
    output logic              sync_pulse,
    output logic [DATA_W-1:0] rdata
);
    // Store the modulation select and general bits on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mod <= 1'b0;
            misc   <= '0;
        end else if (wr_en) begin
            tx_mod <= wdata[CF_TXMOD];
            misc   <= wdata[MISC_W-1:0];
        end
    end

    // Produce a single-cycle trigger in the cycle after a write with the sync bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_pulse <= 1'b0;
        else        sync_pulse <= wr_en && wdata[CF_SYNC];
    end

    // Read back stored bits; the trigger position always reads zero.
    always_comb begin
        rdata               = '0;
        rdata[CF_TXMOD]     = tx_mod;
        rdata[MISC_W-1:0]   = misc;
    end
endmodule

// File: rtl/sysopt_stop_ctrl.sv
// Module: STOP legality check and fast-wakeup hazard monitor.
// Assumes stop_req and irq are synchronous single-clock-domain signals.
// A qualifying strobe opens a window of HAZ_WIN+1 cycles (strobe cycle included).
module sysopt_stop_ctrl #(
    parameter int HAZ_WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic stop_en,
    input  logic fast_wake,
    input  logic irq,
    output logic stop_grant,
    output logic illegal_rst,
    output logic wake_hazard
);
    localparam int CNT_W = $clog2(HAZ_WIN + 1);

    logic [CNT_W-1:0] win_cnt;
    logic             arm;
    logic             win_open;

    // Decide whether this strobe opens the hazard window and whether the window is open now.
    always_comb begin
        arm      = stop_req && stop_en && fast_wake;
        win_open = arm || (win_cnt != '0);
    end

    // Turn each strobe into exactly one of grant or illegal-reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_grant  <= 1'b0;
            illegal_rst <= 1'b0;
        end else begin
            stop_grant  <= stop_req && stop_en;
            illegal_rst <= stop_req && !stop_en;
        end
    end

    // Count down the remaining cycles of the post-STOP window.
    always_ff @(posedge clk) begin
        if (!rst_n)            win_cnt <= '0;
        else if (arm)          win_cnt <= CNT_W'(HAZ_WIN);
        else if (win_cnt != '0) win_cnt <= win_cnt - CNT_W'(1);
    end

    // Flag an interrupt that lands inside the open window.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_hazard <= 1'b0;
        else        wake_hazard <= win_open && irq;
    end
endmodule

// File: rtl/sysopt_tx_path.sv
// Module: transmit path select. Either passes data straight through or
// gates it with a PWM channel. Assumes both inputs are bus-clock synchronous.
module sysopt_tx_path (
    input  logic tx_mod,
    input  logic tx_data,
    input  logic pwm_ch,
    output logic tx_pin
);
    // Choose the direct or the modulated transmit level.
    always_comb begin
        tx_pin = tx_mod ? (tx_data & pwm_ch) : tx_data;
    end
endmodule

// File: rtl/sysopt_ctrl.sv
// Module: top of the system options block. Decodes the register bus,
// routes read data and connects the lock, configuration, stop and
// transmit sub-blocks. Assumes a single synchronous bus clock.
module sysopt_ctrl
    import sysopt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int HAZ_WIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              stop_req_i,
    input  logic              irq_i,
    output logic              stop_grant_o,
    output logic              illegal_rst_o,
    output logic              fast_wake_o,
    output logic              wake_hazard_o,
    input  logic              tx_data_i,
    input  logic              pwm_ch_i,
    output logic              tx_pin_o,
    output logic              sync_pulse_o,
    output logic [5:0]        cfg_misc_o
);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);

    logic              hit_lock;
    logic              hit_cfg;
    logic              wr_lock;
    logic              wr_cfg;
    lock_opts_t        lock_q;
    logic              lock_done;
    logic              stop_en_q;
    logic              fast_wake_q;
    logic              tx_mod_q;
    logic [DATA_W-1:0] lock_rd;
    logic [DATA_W-1:0] cfg_rd;

    // Decode the offset and qualify writes per register.
    always_comb begin
        hit_lock = bus_sel && (bus_addr == A_LOCK);
        hit_cfg  = bus_sel && (bus_addr == A_CFG);
        wr_lock  = hit_lock && bus_we;
        wr_cfg   = hit_cfg && bus_we;
    end

    sysopt_lock_reg u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_lock),
        .wdata  (bus_wdata[1:0]),
        .opts   (lock_q),
        .locked (lock_done),
        .rdata  (lock_rd)
    );

    sysopt_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_cfg),
        .wdata      (bus_wdata),
        .tx_mod     (tx_mod_q),
        .misc       (cfg_misc_o),
        .sync_pulse (sync_pulse_o),
        .rdata      (cfg_rd)
    );

    // Break out the stored lock options for the stop logic and the port.
    always_comb begin
        stop_en_q   = lock_q.stop_en;
        fast_wake_q = lock_q.fast_wake;
        fast_wake_o = fast_wake_q;
    end

    sysopt_stop_ctrl #(.HAZ_WIN(HAZ_WIN)) u_stop (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req_i),
        .stop_en     (stop_en_q),
        .fast_wake   (fast_wake_q),
        .irq         (irq_i),
        .stop_grant  (stop_grant_o),
        .illegal_rst (illegal_rst_o),
        .wake_hazard (wake_hazard_o)
    );

    sysopt_tx_path u_tx (
        .tx_mod  (tx_mod_q),
        .tx_data (tx_data_i),
        .pwm_ch  (pwm_ch_i),
        .tx_pin  (tx_pin_o)
    );

    // Return the selected register, or zero for unmapped offsets and idle bus.
    always_comb begin
        if (hit_lock)     bus_rdata = lock_rd;
        else if (hit_cfg) bus_rdata = cfg_rd;
        else              bus_rdata = '0;
    end
endmodule

// File: rtl/sysopt_ctrl_chk.sv
// Module: property checker for sysopt_ctrl, attached through bind.
// Assumes inputs are synchronous to clk and stable around its rising edge.
module sysopt_ctrl_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sync_bit,
    input logic              stop_req_i,
    input logic              tx_data_i,
    input logic              stop_grant_o,
    input logic              illegal_rst_o,
    input logic              sync_pulse_o,
    input logic              tx_pin_o,
    input logic              stop_en,
    input logic              fast_wake,
    input logic              locked,
    input logic              tx_mod
);
    logic sync_wr;

    // Recognise a write that should fire the sync trigger.
    always_comb sync_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(sysopt_pkg::OFS_CFG)) && sync_bit;

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_grant_o && illegal_rst_o));
    a_r3_illegal_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_i && !stop_en) |=> (illegal_rst_o && !stop_grant_o));
    a_r4_grant_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_i && stop_en) |=> (stop_grant_o && !illegal_rst_o));
    a_r4_no_strobe_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req_i |=> (!stop_grant_o && !illegal_rst_o));
    a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(stop_en) && $stable(fast_wake)));
    a_r8_sync_fires: assert property (@(posedge clk) disable iff (!rst_n)
        sync_wr |=> sync_pulse_o);
    a_r8_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_wr |=> !sync_pulse_o);
    a_r9_low_data_low_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_data_i |-> !tx_pin_o);
    a_r9_direct_path: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mod |-> (tx_pin_o == tx_data_i));
endmodule

bind sysopt_ctrl sysopt_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .sync_bit      (bus_wdata[6]),
    .stop_req_i    (stop_req_i),
    .tx_data_i     (tx_data_i),
    .stop_grant_o  (stop_grant_o),
    .illegal_rst_o (illegal_rst_o),
    .sync_pulse_o  (sync_pulse_o),
    .tx_pin_o      (tx_pin_o),
    .stop_en       (stop_en_q),
    .fast_wake     (fast_wake_q),
    .locked        (lock_done),
    .tx_mod        (tx_mod_q)
);

// File: tb/sysopt_ctrl_bench.sv
// Bench: sweeps the configuration register over all byte values, every
// lock-register write pair, every unmapped offset and every interrupt
// offset around a STOP strobe. Drives and samples on the falling edge.
module sysopt_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 3;
    localparam int HAZ_WIN    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              stop_req_i = 1'b0;
    logic              irq_i = 1'b0;
    logic              stop_grant_o;
    logic              illegal_rst_o;
    logic              fast_wake_o;
    logic              wake_hazard_o;
    logic              tx_data_i = 1'b0;
    logic              pwm_ch_i = 1'b0;
    logic              tx_pin_o;
    logic              sync_pulse_o;
    logic [5:0]        cfg_misc_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysopt_ctrl #(.ADDR_W(ADDR_W), .HAZ_WIN(HAZ_WIN)) u_sysopt_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_req_i(stop_req_i), .irq_i(irq_i), .stop_grant_o(stop_grant_o),
        .illegal_rst_o(illegal_rst_o), .fast_wake_o(fast_wake_o),
        .wake_hazard_o(wake_hazard_o), .tx_data_i(tx_data_i), .pwm_ch_i(pwm_ch_i),
        .tx_pin_o(tx_pin_o), .sync_pulse_o(sync_pulse_o), .cfg_misc_o(cfg_misc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; stop_req_i = 1'b0; irq_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write returns at the falling edge right after the capturing rising edge.
    task automatic bus_write(input int addr, input logic [7:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [7:0] data);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
        #1 data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Issue one STOP strobe and return the two outputs in the following cycle.
    task automatic do_stop(output logic grant, output logic ill);
        @(negedge clk);
        stop_req_i = 1'b1;
        @(negedge clk);
        stop_req_i = 1'b0;
        grant = stop_grant_o;
        ill   = illegal_rst_o;
    endtask

    initial begin
        logic [7:0] rd;
        logic       g;
        logic       il;

        do_reset();
        // R1: reset state
        @(negedge clk);
        tx_data_i = 1'b1; pwm_ch_i = 1'b0;
        bus_read(4, rd); check("R1 lock reads zero", rd, 8'h00);
        bus_read(5, rd); check("R1 cfg reads zero", rd, 8'h00);
        check("R1 outputs idle", {stop_grant_o, illegal_rst_o, wake_hazard_o, sync_pulse_o, fast_wake_o}, 5'b0);
        check("R1 tx passthrough", tx_pin_o, 1'b1);
        check("R11 misc reset", cfg_misc_o, 6'h00);

        // R10: unmapped offsets read zero, ignore writes, do not lock
        for (int a = 0; a < 8; a++) begin
            if (a == 4 || a == 5) continue;
            bus_write(a, 8'hFF);
            bus_read(a, rd); check("R10 unmapped read", rd, 8'h00);
        end
        bus_read(4, rd); check("R10 lock untouched", rd, 8'h00);
        bus_read(5, rd); check("R10 cfg untouched", rd, 8'h00);
        bus_write(4, 8'h03);
        bus_read(4, rd); check("R10 lock still open after unmapped writes", rd, 8'h03);
        bus_sel = 1'b0; bus_addr = 3'd4; #1;
        check("R10 idle bus reads zero", bus_rdata, 8'h00);

        // R2, R3, R4, R5: every first/second write pair to the lock register
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 4; s++) begin
                do_reset();
                bus_write(4, {6'b101101, 2'(f)});
                bus_read(4, rd); check("R2 first write stored", rd, 8'(f));
                bus_write(4, {6'b010010, 2'(s)});
                bus_read(4, rd); check("R2 second write ignored", rd, 8'(f));
                check("R5 fast wake output", fast_wake_o, f[1]);
                do_stop(g, il);
                if (f[0]) begin
                    check("R4 grant on enabled stop", {g, il}, 2'b10);
                end else begin
                    check("R3 illegal on disabled stop", {g, il}, 2'b01);
                end
                @(negedge clk);
                check("R4 R3 pulse lasts one cycle", {stop_grant_o, illegal_rst_o}, 2'b00);
            end
        end

        // R7, R8, R9, R11: every byte value in the configuration register
        do_reset();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            vb = 8'(v);
            bus_write(5, vb);
            check("R8 sync pulse follows bit 6", sync_pulse_o, vb[6]);
            bus_read(5, rd); check("R7 readback bit 6 zero", rd, vb & 8'hBF);
            check("R11 misc bits", cfg_misc_o, vb[5:0]);
            for (int t = 0; t < 4; t++) begin
                tx_data_i = t[0]; pwm_ch_i = t[1];
                #1;
                check("R9 tx path", tx_pin_o, vb[7] ? (t[0] & t[1]) : t[0]);
            end
            @(negedge clk);
            check("R8 sync pulse one cycle", sync_pulse_o, 1'b0);
        end

        // R6: interrupt offset sweep around a STOP strobe
        for (int fw = 0; fw < 2; fw++) begin
            for (int k = 0; k <= HAZ_WIN + 2; k++) begin
                do_reset();
                bus_write(4, fw[0] ? 8'h03 : 8'h01);
                @(negedge clk);
                stop_req_i = 1'b1;
                irq_i = (k == 0);
                for (int j = 1; j <= k + 1; j++) begin
                    @(negedge clk);
                    stop_req_i = 1'b0;
                    if (j == k + 1)
                        check("R6 hazard window", wake_hazard_o, (fw == 1) && (k <= HAZ_WIN));
                    irq_i = (j == k);
                end
                irq_i = 1'b0;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule